// File: doc/BRIEF.md
# Match-Driven Output Pin Controller

This block turns timer match events into four output pin levels. Each channel owns a stored state bit that reacts to a match pulse through a 2-bit action code, which can keep the bit, force it low, force it high or invert it. Software can also load these state bits directly through a small register bus. A match on a channel in the same cycle as a software load wins for that channel.

Each pin passes through two selection stages. A PWM enable picks either a compare waveform (count at or above the channel's match value) or the stored state bit. An IO enable then picks either that timer-side level or a GPIO value supplied from outside. Pins and read data are registered. The counter itself lives elsewhere: this block only receives the count, the match values and the match pulses.

Top module: `match_pin_ctrl`

## Requirements
- R1: After synchronous reset every state bit, action code, PWM enable and IO enable is zero, every pin is low and the read data is zero.
- R2: Register layout. At offset 0x30, bits [3:0] are the state bits of channels 0..3 and bits [4+2n+1:4+2n] are the action code of channel n. At offset 0x34, bits [3:0] are the PWM enables and bits [23:20] are the IO enables. All other bits, and all other offsets, read as zero. Read data appears on the clock edge after the address is presented.
- R3: When a channel's match pulse is high at a clock edge, its state bit is updated at that edge according to its action code: 0 keeps it, 1 clears it, 2 sets it, 3 inverts it.
- R4: A write to offset 0x30 loads bit n of the write data into the state bit of every channel whose match pulse is low in that cycle. The same write loads the action codes.
- R5: When a channel's match pulse and a write to offset 0x30 occur in the same cycle, the match result (including "keep" for code 0) replaces the written value for that channel. Channels without a match still take the written value.
- R6: With IO enable 1 and PWM enable 0, the pin shows the channel's state bit one clock later.
- R7: With IO enable 1 and PWM enable 1, the pin is high one clock after a cycle in which the count is greater than or equal to the channel's match value, and low otherwise.
- R8: With IO enable 0, the pin shows the channel's GPIO input one clock later, whatever the PWM enable is.
- R9: Channels are independent: the actions, matches, modes and GPIO values of one channel do not change another channel's state bit or pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for reg_addr |
| match_pulse | input | NUM_CH | Per-channel match event, one bit per channel |
| count_val | input | CNT_W | Current timer count |
| match_val | input | NUM_CH*CNT_W | Match values, channel n at bits [n*CNT_W +: CNT_W] |
| gpio_val | input | NUM_CH | GPIO levels used when a pin is handed to GPIO |
| pin_out | output | NUM_CH | Registered pin levels |

## Verification
The bench builds the block with four channels and an 8-bit count, so random counts and match values cover the whole compare range, including a match value of 0 (pin always high) and 255 (pin high only at the top count). Random writes land on both registers and on an unmapped offset while random match pulses hit every action code, which brings same-cycle write and match collisions and every pin mode into frequent reach, all compared against a behavioural model every clock.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  // Action taken on a channel's state bit when its match pulse fires.
  typedef enum logic [1:0] {
    ACT_KEEP   = 2'd0,
    ACT_CLEAR  = 2'd1,
    ACT_SET    = 2'd2,
    ACT_INVERT = 2'd3
  } match_act_e;

  // Field placement inside the two registers.
  localparam int ACT_LSB  = 4;
  localparam int ACT_W    = 2;
  localparam int IOEN_LSB = 20;

endpackage

// File: rtl/mpc_cfg_regs.sv
module mpc_cfg_regs
  import mpc_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int STATE_OFS = 'h30,
  parameter int MODE_OFS  = 'h34
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NUM_CH-1:0]             state_i,
  output logic [NUM_CH-1:0][ACT_W-1:0]  act_o,
  output logic [NUM_CH-1:0]             pwm_en_o,
  output logic [NUM_CH-1:0]             io_en_o,
  output logic                          state_wr_o,
  output logic [NUM_CH-1:0]             state_wdata_o,
  output logic [DATA_W-1:0]             rdata_o
);

  localparam logic [ADDR_W-1:0] STATE_A = ADDR_W'(STATE_OFS);
  localparam logic [ADDR_W-1:0] MODE_A  = ADDR_W'(MODE_OFS);

  logic [NUM_CH-1:0][ACT_W-1:0] act_q;
  logic [NUM_CH-1:0]            pwm_q;
  logic [NUM_CH-1:0]            io_q;
  logic [DATA_W-1:0]            rdata_q;
  logic [DATA_W-1:0]            rd_mux;
  logic                         hit_state;
  logic                         hit_mode;
  logic                         unused_wdata_bits;

  assign hit_state = wr_en_i && (addr_i == STATE_A);
  assign hit_mode  = wr_en_i && (addr_i == MODE_A);
  assign unused_wdata_bits = ^wdata_i;

  always_comb begin
    rd_mux = '0;
    if (addr_i == STATE_A) begin
      rd_mux[NUM_CH-1:0] = state_i;
      for (int n = 0; n < NUM_CH; n++) begin
        rd_mux[ACT_LSB + ACT_W*n +: ACT_W] = act_q[n];
      end
    end else if (addr_i == MODE_A) begin
      rd_mux[NUM_CH-1:0]          = pwm_q;
      rd_mux[IOEN_LSB +: NUM_CH]  = io_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= '0;
      pwm_q   <= '0;
      io_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (hit_state) begin
        for (int n = 0; n < NUM_CH; n++) begin
          act_q[n] <= wdata_i[ACT_LSB + ACT_W*n +: ACT_W];
        end
      end
      if (hit_mode) begin
        pwm_q <= wdata_i[NUM_CH-1:0];
        io_q  <= wdata_i[IOEN_LSB +: NUM_CH];
      end
      rdata_q <= rd_mux;
    end
  end

  assign act_o         = act_q;
  assign pwm_en_o      = pwm_q;
  assign io_en_o       = io_q;
  assign state_wr_o    = hit_state;
  assign state_wdata_o = wdata_i[NUM_CH-1:0];
  assign rdata_o       = rdata_q;

  // R2: a mode write lands in both enable fields on the next edge
  assert_mode_write_R2: assert property (@(posedge clk) disable iff (rst)
    hit_mode |=> (io_en_o == $past(wdata_i[IOEN_LSB +: NUM_CH]))
                 && (pwm_en_o == $past(wdata_i[NUM_CH-1:0])));

  // R2: unmapped offsets read as zero
  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ((addr_i != STATE_A) && (addr_i != MODE_A)) |=> (rdata_o == '0));

endmodule

// File: rtl/mpc_state_bit.sv
module mpc_state_bit
  import mpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             match_i,
  input  logic [ACT_W-1:0] act_i,
  input  logic             sw_wr_i,
  input  logic             sw_val_i,
  output logic             state_o
);

  logic state_q;
  logic state_d;

  always_comb begin
    state_d = state_q;
    if (match_i) begin
      unique case (match_act_e'(act_i))
        ACT_KEEP:   state_d = state_q;
        ACT_CLEAR:  state_d = 1'b0;
        ACT_SET:    state_d = 1'b1;
        ACT_INVERT: state_d = ~state_q;
      endcase
    end else if (sw_wr_i) begin
      state_d = sw_val_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= 1'b0;
    else     state_q <= state_d;
  end

  assign state_o = state_q;

  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (match_i && act_i == ACT_CLEAR) |=> !state_o);

  assert_set_R3: assert property (@(posedge clk) disable iff (rst)
    (match_i && act_i == ACT_SET) |=> state_o);

  assert_invert_R3: assert property (@(posedge clk) disable iff (rst)
    (match_i && act_i == ACT_INVERT) |=> (state_o != $past(state_o)));

  // R5: keep action beats a same-cycle software load
  assert_keep_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (match_i && act_i == ACT_KEEP) |=> $stable(state_o));

  assert_sw_load_R4: assert property (@(posedge clk) disable iff (rst)
    (!match_i && sw_wr_i) |=> (state_o == $past(sw_val_i)));

endmodule

// File: rtl/mpc_pin_drv.sv
module mpc_pin_drv #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_en_i,
  input  logic             pwm_en_i,
  input  logic             state_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] mval_i,
  input  logic             gpio_i,
  output logic             pin_o
);

  logic wave_lvl;
  logic timer_lvl;
  logic pin_d;
  logic pin_q;

  assign wave_lvl  = (count_i >= mval_i);
  assign timer_lvl = pwm_en_i ? wave_lvl : state_i;
  assign pin_d     = io_en_i ? timer_lvl : gpio_i;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin_d;
  end

  assign pin_o = pin_q;

  assert_gpio_pass_R8: assert property (@(posedge clk) disable iff (rst)
    !io_en_i |=> (pin_o == $past(gpio_i)));

  assert_state_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (io_en_i && !pwm_en_i) |=> (pin_o == $past(state_i)));

  assert_wave_R7: assert property (@(posedge clk) disable iff (rst)
    (io_en_i && pwm_en_i) |=> (pin_o == ($past(count_i) >= $past(mval_i))));

endmodule

// File: rtl/match_pin_ctrl.sv
module match_pin_ctrl
  import mpc_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int STATE_OFS = 'h30,
  parameter int MODE_OFS  = 'h34
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_wr_en,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  input  logic [NUM_CH-1:0]       match_pulse,
  input  logic [CNT_W-1:0]        count_val,
  input  logic [NUM_CH*CNT_W-1:0] match_val,
  input  logic [NUM_CH-1:0]       gpio_val,
  output logic [NUM_CH-1:0]       pin_out
);

  logic [NUM_CH-1:0][ACT_W-1:0] act;
  logic [NUM_CH-1:0]            pwm_en;
  logic [NUM_CH-1:0]            io_en;
  logic                         state_wr;
  logic [NUM_CH-1:0]            state_wdata;
  logic [NUM_CH-1:0]            state;

  mpc_cfg_regs #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .STATE_OFS(STATE_OFS),
    .MODE_OFS (MODE_OFS)
  ) cfg_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en_i      (reg_wr_en),
    .addr_i       (reg_addr),
    .wdata_i      (reg_wdata),
    .state_i      (state),
    .act_o        (act),
    .pwm_en_o     (pwm_en),
    .io_en_o      (io_en),
    .state_wr_o   (state_wr),
    .state_wdata_o(state_wdata),
    .rdata_o      (reg_rdata)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    mpc_state_bit st_i (
      .clk     (clk),
      .rst     (rst),
      .match_i (match_pulse[n]),
      .act_i   (act[n]),
      .sw_wr_i (state_wr),
      .sw_val_i(state_wdata[n]),
      .state_o (state[n])
    );

    mpc_pin_drv #(.CNT_W(CNT_W)) drv_i (
      .clk     (clk),
      .rst     (rst),
      .io_en_i (io_en[n]),
      .pwm_en_i(pwm_en[n]),
      .state_i (state[n]),
      .count_i (count_val),
      .mval_i  (match_val[n*CNT_W +: CNT_W]),
      .gpio_i  (gpio_val[n]),
      .pin_o   (pin_out[n])
    );
  end

  // R1: reset leaves pins and read data low
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pin_out == '0) && (reg_rdata == '0));

endmodule

// File: tb/match_pin_ctrl_tb_top.sv
module match_pin_ctrl_tb_top;

  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int AW  = 8;
  localparam int DW  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr_en = 1'b0;
  logic [AW-1:0]     reg_addr = '0;
  logic [DW-1:0]     reg_wdata = '0;
  logic [DW-1:0]     reg_rdata;
  logic [NCH-1:0]    match_pulse = '0;
  logic [CW-1:0]     count_val = '0;
  logic [NCH*CW-1:0] match_val = '0;
  logic [NCH-1:0]    gpio_val = '0;
  logic [NCH-1:0]    pin_out;

  always #2.5 clk = ~clk;

  match_pin_ctrl #(.NUM_CH(NCH), .CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .match_pulse(match_pulse),
    .count_val(count_val), .match_val(match_val), .gpio_val(gpio_val),
    .pin_out(pin_out)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [3:0]  m_em, m_pwm, m_io, m_pin;
  logic [1:0]  m_act [4];
  logic [31:0] m_rd;
  int          m_mode [4];   // 6 state, 7 wave, 8 gpio
  logic        cmp_on = 1'b0;
  logic [31:0] t_rd;
  logic [3:0]  t_em;

  always @(posedge clk) begin
    if (rst) begin
      m_em <= 0; m_pwm <= 0; m_io <= 0; m_pin <= 0; m_rd <= 0;
      for (int c = 0; c < 4; c++) begin m_act[c] <= 0; m_mode[c] <= 6; end
    end else begin
      t_rd = 0;
      if (reg_addr == 8'h30) begin
        t_rd[3:0] = m_em;
        for (int c = 0; c < 4; c++) t_rd[4+2*c +: 2] = m_act[c];
      end else if (reg_addr == 8'h34) begin
        t_rd[3:0] = m_pwm;
        t_rd[23:20] = m_io;
      end
      m_rd <= t_rd;
      t_em = m_em;
      for (int c = 0; c < 4; c++) begin
        if (!m_io[c]) begin
          m_pin[c] <= gpio_val[c]; m_mode[c] <= 8;
        end else if (m_pwm[c]) begin
          m_pin[c] <= (int'(count_val) >= int'(match_val[c*CW +: CW]));
          m_mode[c] <= 7;
        end else begin
          m_pin[c] <= m_em[c]; m_mode[c] <= 6;
        end
        if (match_pulse[c]) begin
          if (m_act[c] == 1) t_em[c] = 1'b0;
          else if (m_act[c] == 2) t_em[c] = 1'b1;
          else if (m_act[c] == 3) t_em[c] = ~m_em[c];
        end else if (reg_wr_en && reg_addr == 8'h30) begin
          t_em[c] = reg_wdata[c];
        end
      end
      m_em <= t_em;
      if (reg_wr_en && reg_addr == 8'h30)
        for (int c = 0; c < 4; c++) m_act[c] <= reg_wdata[4+2*c +: 2];
      if (reg_wr_en && reg_addr == 8'h34) begin
        m_pwm <= reg_wdata[3:0];
        m_io  <= reg_wdata[23:20];
      end
    end
    cmp_on <= 1'b1;
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      for (int c = 0; c < 4; c++) begin
        string tg;
        tg = (m_mode[c] == 8) ? "R8" : (m_mode[c] == 7) ? "R7" : "R6";
        if (rst) tg = "R1";
        chk(tg, $sformatf("model pin ch%0d", c), 32'(pin_out[c]), 32'(m_pin[c]));
      end
      chk(rst ? "R1" : "R2", "model read data", reg_rdata, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] m);
    reg_wr_en = wr; reg_addr = a; reg_wdata = d; match_pulse = m;
    @(negedge clk);
    reg_wr_en = 1'b0; match_pulse = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired before end of test");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "pins after reset", 32'(pin_out), 0);
    rd(8'h30, d); chk("R1", "state reg after reset", d, 0);
    rd(8'h34, d); chk("R1", "mode reg after reset", d, 0);

    // layout: reserved bits read zero, unmapped offset reads zero
    cyc(1, 8'h34, 32'hFFFF_FFF0, 0);
    rd(8'h34, d); chk("R2", "mode reg reserved bits", d, 32'h00F0_0000);
    rd(8'h40, d); chk("R2", "unmapped offset", d, 0);

    // actions: ch0 set, ch1 clear, ch2 invert, ch3 keep; state 0010
    cyc(1, 8'h30, 32'h0000_0362, 0);
    cyc(0, 8'h30, 0, 4'hF);
    rd(8'h30, d);
    chk("R3", "state after all-channel match", d, 32'h365);
    chk("R9", "per-channel independent results", 32'(d[3:0]), 32'h5);
    chk("R6", "pins follow state bits", 32'(pin_out), 32'h5);
    cyc(0, 8'h30, 0, 4'b0100);
    rd(8'h30, d); chk("R3", "invert on ch2", d, 32'h361);

    // collision: write 1111 while ch1 (clear) and ch3 (keep) match
    cyc(1, 8'h30, 32'h0000_036F, 4'b1010);
    rd(8'h30, d); chk("R5", "match beats write", d, 32'h365);
    cyc(1, 8'h30, 32'h0000_036A, 0);
    rd(8'h30, d); chk("R4", "plain software load", d, 32'h36A);

    // wave mode on ch0/ch1
    match_val = {8'd255, 8'd0, 8'd20, 8'd10};
    cyc(1, 8'h34, 32'h00F0_0003, 0);
    count_val = 8'd9;  @(negedge clk);
    chk("R7", "ch0 below threshold", 32'(pin_out[0]), 0);
    count_val = 8'd10; @(negedge clk);
    chk("R7", "ch0 at threshold", 32'(pin_out[0]), 1);
    chk("R7", "ch1 below threshold", 32'(pin_out[1]), 0);
    count_val = 8'd20; @(negedge clk);
    chk("R7", "ch1 at threshold", 32'(pin_out[1]), 1);

    // GPIO hand-over on ch2 with its wave enable also set
    cyc(1, 8'h34, 32'h00B0_0007, 0);
    gpio_val = 4'b0100; @(negedge clk);
    chk("R8", "ch2 gpio high", 32'(pin_out[2]), 1);
    chk("R6", "ch3 still on state bit", 32'(pin_out[3]), 1);
    gpio_val = 4'b0000; @(negedge clk);
    chk("R8", "ch2 gpio low", 32'(pin_out[2]), 0);

    // random traffic, model compared every clock (R9 mixed channels)
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      reg_wr_en   = (sel < 4);
      reg_addr    = (sel % 3 == 0) ? 8'h30 : (sel % 3 == 1) ? 8'h34 : 8'h31;
      reg_wdata   = $urandom;
      match_pulse = 4'($urandom);
      gpio_val    = 4'($urandom);
      count_val   = 8'($urandom);
      if (sel == 9) match_val = {$urandom};
      @(negedge clk);
    end
    reg_wr_en = 1'b0; match_pulse = '0;
    @(negedge clk);
    summary();
    $finish;
  end

endmodule